// File: doc/BRIEF.md
# Folded Three-Operand Adder

This block adds three signed words, producing y = a + b + c for every input sample, and it does so with a single pipelined two-input adder. The two additions are time-multiplexed onto that adder with a folding factor of two. In the first cycle of a sample the adder sums a and b. In the second cycle it sums that partial result with c.

A free-running phase counter starts at the first phase on the first cycle after reset. It selects the adder operands through a multiplexer. The adder's own pipeline register holds the partial sum between the two phases, so the feedback path needs no extra delay.

The source must present a new sample every two cycles, aligned to the first phase, and hold it steady across both cycles. One result word leaves per two cycles, marked by a single-cycle valid strobe. The result is two bits wider than the operands, so it can never overflow.

Top module: `fold_sum3`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the next cycle shows y_valid low, y_out zero and the phase counter at phase 0.
- R2: The phase alternates every cycle. Phase 0 is the first cycle after reset is released, and the phases go 0, 1, 0, 1 from there.
- R3: A sample presented in cycles 2n and 2n+1 after reset release gives y_out equal to a + b + c. The sum is computed exactly, with sign extension to W+2 bits, and is visible in cycle 2n+2.
- R4: y_valid is high for exactly one cycle after each phase-1 cycle, which is every even cycle from cycle 2 on. It is low in all other cycles, including cycle 0 after reset.
- R5: Operands at the signed extremes give the exact result with no wrap. All at the maximum gives 3·(2^(W-1)-1); all at the minimum gives -3·2^(W-1).
- R6: The values of a_in and b_in during the phase-1 cycle have no effect on the result.
- R7: The value of c_in during the phase-0 cycle has no effect on the result.
- R8: A reset asserted in the middle of a sample discards that sample. No valid result for it ever appears, and the schedule restarts at phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | First signed operand, used in phase 0 |
| b_in | input | W | Second signed operand, used in phase 0 |
| c_in | input | W | Third signed operand, used in phase 1 |
| y_out | output | W+2 | Signed sum, meaningful while y_valid is high |
| y_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with W = 8. This makes the signed extremes and the carries into both extension bits common under random stimulus, not rare. It also lets directed samples reach the largest positive and negative totals directly.

Some samples change a and b in the phase-1 cycle, or c in the phase-0 cycle. These reach the operand steering, where only a correct phase-to-operand pairing gives the expected sum. A reset issued halfway through a sample exercises the restart of the schedule.

// File: rtl/fold_sum3_pkg.sv
package fold_sum3_pkg;

    // Folding order of the shared adder
    typedef enum logic {
        PH_FIRST  = 1'b0,   // a + b
        PH_SECOND = 1'b1    // partial + c
    } fold_phase_e;

    localparam int unsigned FOLD_FACTOR = 2;
    localparam int unsigned GUARD_BITS  = 2;

endpackage

// File: rtl/fold_phase_ctrl.sv
module fold_phase_ctrl #(
    parameter int unsigned NFOLD = 2,
    localparam int unsigned PW   = (NFOLD > 1) ? $clog2(NFOLD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic          last_phase
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.cnt == PW'(NFOLD - 1)) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase      = state_q.cnt;
    assign last_phase = (state_q.cnt == PW'(NFOLD - 1));

endmodule

// File: rtl/fold_operand_mux.sv
module fold_operand_mux #(
    parameter int unsigned W  = 16,
    parameter int unsigned SW = W + 2
) (
    input  logic          sel_second,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [W-1:0]  c_in,
    input  logic [SW-1:0] partial,
    output logic [SW-1:0] op_x,
    output logic [SW-1:0] op_y
);

    localparam int unsigned EXT = SW - W;

    logic [SW-1:0] a_ext, b_ext, c_ext;

    always_comb begin
        a_ext = {{EXT{a_in[W-1]}}, a_in};
        b_ext = {{EXT{b_in[W-1]}}, b_in};
        c_ext = {{EXT{c_in[W-1]}}, c_in};
        if (sel_second) begin
            op_x = partial;
            op_y = c_ext;
        end else begin
            op_x = a_ext;
            op_y = b_ext;
        end
    end

endmodule

// File: rtl/fold_pipe_adder.sv
module fold_pipe_adder #(
    parameter int unsigned SW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] op_x,
    input  logic [SW-1:0] op_y,
    output logic [SW-1:0] sum_q
);

    typedef struct packed {
        logic [SW-1:0] sum;
    } add_state_t;

    add_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.sum = op_x + op_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum_q = state_q.sum;

endmodule

// File: rtl/fold_sum3.sv
module fold_sum3 #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [W-1:0]   c_in,
    output logic [W+1:0]   y_out,
    output logic           y_valid
);

    import fold_sum3_pkg::*;

    localparam int unsigned SW = W + GUARD_BITS;
    localparam int unsigned PW = (FOLD_FACTOR > 1) ? $clog2(FOLD_FACTOR) : 1;

    typedef struct packed {
        logic valid;
    } top_state_t;

    logic [PW-1:0] phase_q;
    logic          last_q;
    logic [SW-1:0] op_x, op_y;
    logic [SW-1:0] sum_q;
    fold_phase_e   phase_e;

    top_state_t state_d, state_q;

    fold_phase_ctrl #(.NFOLD(FOLD_FACTOR)) i_phase (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase_q),
        .last_phase (last_q)
    );

    always_comb begin
        phase_e = fold_phase_e'(phase_q[0]);
    end

    fold_operand_mux #(.W(W), .SW(SW)) i_mux (
        .sel_second (phase_e == PH_SECOND),
        .a_in       (a_in),
        .b_in       (b_in),
        .c_in       (c_in),
        .partial    (sum_q),
        .op_x       (op_x),
        .op_y       (op_y)
    );

    fold_pipe_adder #(.SW(SW)) i_add (
        .clk   (clk),
        .rst   (rst),
        .op_x  (op_x),
        .op_y  (op_y),
        .sum_q (sum_q)
    );

    // The final addition runs in the last phase; its result leaves the
    // one-stage adder pipeline in the following cycle.
    always_comb begin
        state_d       = state_q;
        state_d.valid = last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign y_out   = sum_q;
    assign y_valid = state_q.valid;

endmodule

// File: rtl/fold_sum3_chk.sv
module fold_sum3_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         phase,
    input logic [W+1:0] part,
    input logic [W-1:0] c_in,
    input logic [W+1:0] y_out,
    input logic         y_valid
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!y_valid && y_out == '0 && phase == 1'b0));

    assert_phase_up_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 1'b0) |=> (phase == 1'b1));

    assert_phase_down_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 1'b1) |=> (phase == 1'b0));

    assert_sum_exact_R3: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (y_out == $past(part) + {{2{$past(c_in[W-1])}}, $past(c_in)}));

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 1'b1) |=> y_valid);

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

    assert_valid_phase_R4: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (phase == 1'b0));

endmodule

bind fold_sum3 fold_sum3_chk #(.W(W)) i_fold_sum3_chk (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase_q[0]),
    .part    (sum_q),
    .c_in    (c_in),
    .y_out   (y_out),
    .y_valid (y_valid)
);

// File: tb/test_fold_sum3.sv
module test_fold_sum3;

    localparam int unsigned W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   a_in = '0, b_in = '0, c_in = '0;
    logic [W+1:0]   y_out;
    logic           y_valid;

    int errors = 0;
    int checks = 0;
    logic           have_prev = 1'b0;
    logic [W+1:0]   prev_exp  = '0;

    always #2 clk = ~clk;   // 250 MHz

    fold_sum3 #(.W(W)) i_fold_sum3 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .y_out(y_out), .y_valid(y_valid)
    );

    function automatic logic [W+1:0] ext(input logic [W-1:0] v);
        return {{2{v[W-1]}}, v};
    endfunction

    function automatic logic [W+1:0] sum3(input logic [W-1:0] a, b, c);
        return ext(a) + ext(b) + ext(c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One sample: phase-0 inputs then phase-1 inputs; starts and ends at negedge
    task automatic sample(input logic [W-1:0] a0, b0, c0, a1, b1, c1, input string req);
        a_in = a0; b_in = b0; c_in = c0;
        // phase 0 cycle: previous result must be visible (R4, R3)
        chk("R4 valid in phase 0", 32'(y_valid), 32'(have_prev));
        if (have_prev) chk({req, " result"}, 32'(y_out), 32'(prev_exp));
        @(posedge clk); @(negedge clk);
        a_in = a1; b_in = b1; c_in = c1;
        chk("R4 valid low in phase 1", 32'(y_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        prev_exp  = sum3(a0, b0, c1);
        have_prev = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb, rc, xa, xb, xc;
        void'($urandom(32'h5EED_F01D));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(y_valid), 32'd0);
        chk("R1 y in reset", 32'(y_out), 32'd0);
        rst = 1'b0;
        // R2: first cycle after release is phase 0, so the first strobe is in cycle 2
        sample(8'sd5, 8'sd7, 8'sd100, 8'sd5, 8'sd7, 8'sd9, "R3 directed");
        sample(8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, "R5 all max");
        sample(8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, "R5 all min");
        sample(8'h7F, 8'h80, 8'hFF, 8'h7F, 8'h80, 8'hFF, "R3 mixed");
        sample(8'sd1, 8'sd2, 8'h55, 8'h80, 8'h7F, 8'sd3, "R6 R7 changed");
        for (int i = 0; i < 300; i++) begin
            ra = W'($urandom); rb = W'($urandom); rc = W'($urandom);
            xa = W'($urandom); xb = W'($urandom); xc = W'($urandom);
            if (i % 4 == 0)
                sample(ra, rb, xc, xa, xb, rc, "R6 R7 random");
            else
                sample(ra, rb, rc, ra, rb, rc, "R3 random");
        end
        // R8: reset in the middle of a sample
        a_in = 8'sd10; b_in = 8'sd20; c_in = 8'sd30;
        chk("R4 valid before R8", 32'(y_valid), 32'd1);
        chk("R3 result before R8", 32'(y_out), 32'(prev_exp));
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 valid after mid reset", 32'(y_valid), 32'd0);
        chk("R8 y after mid reset", 32'(y_out), 32'd0);
        rst = 1'b0;
        have_prev = 1'b0;
        sample(8'hF0, 8'sd3, 8'sd1, 8'hF0, 8'sd3, 8'sd4, "R8 restart");
        sample(8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, "R8 restart");
        chk("R4 valid final", 32'(y_valid), 32'd1);
        chk("R3 final", 32'(y_out), 32'(prev_exp));
        @(posedge clk); @(negedge clk);
        chk("R4 single cycle", 32'(y_valid), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule